// File: doc/BRIEF.md
# Parallel ATA Host Bus Timing Engine

This block sits between a CPU-facing register interface and a parallel ATA cable. Software loads a per-command control word that carries the drive register address, a direction flag, a choice of data source (the CPU data field or a word stream fed by an external DMA engine), a choice of handshake (programmed strobes or DMA request/acknowledge) and a multi-word flag. The engine then produces the address, data-enable and active-low read/write strobes with cycle counts taken from a set of timing inputs. Separate counts apply to programmed strobes and to DMA handshaking.

Each word passes through an optional setup phase, a strobe phase and an optional hold phase. Burst length is counted in 16-bit words, so software loads a byte count shifted right by one. Status exposes busy, transmit-ready (write words), data-available (read words) and the last word read. On the final word of a command the ready flag always rises one cycle before busy falls. This ordering lets a polling loop that reads busy after the ready flag never miss the end of a burst.

Top module: `pata_host_engine`

## Requirements
- R1: After reset, st_busy, st_tr_rdy, st_dav and ata_doe are 0, and ata_dior_n, ata_diow_n and ata_dmack_n are 1.
- R2: A ctl_we pulse seen while cfg_en is 1 and the engine is idle is accepted, and st_busy reads 1 in the cycle after that edge.
- R3: With strobe handshaking, each word spends one grant cycle, then cfg_pio_setup cycles with the address driven and both strobes high, then max(cfg_pio_strobe,1) cycles with the strobe low, then cfg_pio_hold cycles. A word therefore lasts 1+S+T+H cycles, and the first strobe is low S+1 cycles after acceptance.
- R4: ctl_rd=1 pulses ata_dior_n only and ctl_rd=0 pulses ata_diow_n only. The two strobes are never low together. A write drives ata_doe=1 and the word on ata_dout through setup, strobe and hold.
- R5: A read samples ata_din on the last strobe cycle. At the end of the word st_dav is set, and it stays set until the next command is accepted. st_rdata holds the word read last.
- R6: With ctl_multi=1 the engine moves as many words as the count register held at acceptance. A count of 0, or ctl_multi=0, moves one word. st_busy stays 1 across the whole burst. st_tr_rdy rises at the end of every write word and clears when the next word is granted.
- R7: On the last word, st_tr_rdy (write) or st_dav (read) is 1 in the cycle before st_busy falls, and st_busy falls exactly one cycle after the ready flag rises.
- R8: With ctl_src_dma=1, write words come from str_in_data, which is consumed on the cycle str_in_pop is 1. Each read word is presented once on str_out_data with a one-cycle str_out_valid.
- R9: With ctl_hs_dma=1, each word waits for ata_dmarq=1 and has no setup phase. It uses cfg_dma_strobe and cfg_dma_hold, and holds ata_dmack_n low only while the strobe or hold phase is in progress.
- R10: A ctl_we pulse while st_busy is 1 is ignored. Address, direction and word count of the running command are unchanged.
- R11: While cfg_en is 0, commands are ignored. One cycle after cfg_en falls, the engine is idle with st_busy 0 and both strobes high.
- R12: Timing counts up to 19 are honoured, which covers the slowest strobe mode (setup 4, strobe 19, hold 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Engine enable |
| cfg_pio_setup | input | TIM_W | Setup cycles, strobe handshake |
| cfg_pio_strobe | input | TIM_W | Strobe-low cycles, strobe handshake (0 acts as 1) |
| cfg_pio_hold | input | TIM_W | Hold cycles, strobe handshake |
| cfg_dma_strobe | input | TIM_W | Strobe-low cycles, DMA handshake (0 acts as 1) |
| cfg_dma_hold | input | TIM_W | Hold cycles, DMA handshake |
| cnt_we | input | 1 | Load word count register |
| cnt_words | input | CNT_W | Word count value (16-bit words) |
| ctl_we | input | 1 | Command write strobe |
| ctl_addr | input | ADDR_W | Drive register address |
| ctl_rd | input | 1 | 1 read, 0 write |
| ctl_src_dma | input | 1 | 1 data from/to stream port, 0 CPU field |
| ctl_hs_dma | input | 1 | 1 DMA request/ack handshake, 0 strobes only |
| ctl_multi | input | 1 | Multi-word burst |
| ctl_data | input | DATA_W | CPU write data |
| st_busy | output | 1 | Command in progress |
| st_tr_rdy | output | 1 | Write word completed |
| st_dav | output | 1 | Read data available |
| st_rdata | output | DATA_W | Last word read |
| str_in_data | input | DATA_W | Stream write word |
| str_in_valid | input | 1 | Stream write word present |
| str_in_pop | output | 1 | Stream write word consumed this cycle |
| str_out_data | output | DATA_W | Stream read word |
| str_out_valid | output | 1 | Stream read word valid (one cycle) |
| ata_addr | output | ADDR_W | Drive register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dout | output | DATA_W | Data bus out |
| ata_doe | output | 1 | Data bus output enable |
| ata_din | input | DATA_W | Data bus in |
| ata_dmarq | input | 1 | Drive DMA request |
| ata_dmack_n | output | 1 | DMA acknowledge, active low |

## Verification
Counting from the clock edge that accepts a command, the first strobe falls S+1 cycles later. Each word ends after a further 1+S+T+H cycles, counted from the previous word's end, and the ready flag of word n rises at n·(1+S+T+H). Busy falls one cycle after that, and any DMA request wait shifts all of these by its own length. Inputs are driven and outputs sampled on the falling edge, with a cycle index counted from the accepting edge. Each measured index (first strobe, strobe-low total, ready rise, busy fall) is compared with these formulas, computed from the bench's own timing values across a sweep of setup, strobe and hold counts, directions and burst lengths.

// File: rtl/pata_pkg.sv
package pata_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD,
      ST_DONE
   } pata_state_e;

   typedef struct packed {
      logic rd;
      logic src_dma;
      logic hs_dma;
   } pata_op_t;

endpackage

// File: rtl/pata_timing_sel.sv
module pata_timing_sel #(
   parameter int TIM_W     = 5,
   parameter bit HS_DMA_EN = 1'b1
) (
   input  logic             hs_req,
   input  logic [TIM_W-1:0] pio_setup,
   input  logic [TIM_W-1:0] pio_strobe,
   input  logic [TIM_W-1:0] pio_hold,
   input  logic [TIM_W-1:0] dma_strobe,
   input  logic [TIM_W-1:0] dma_hold,
   output logic             hs_eff,
   output logic [TIM_W-1:0] setup_len,
   output logic [TIM_W-1:0] strobe_len,
   output logic [TIM_W-1:0] hold_len
);
   localparam logic [TIM_W-1:0] ONE = TIM_W'(1);

   logic [TIM_W-1:0] raw_strobe;

   generate
      if (HS_DMA_EN) begin : g_dma_hs
         assign hs_eff = hs_req;
      end else begin : g_pio_only
         assign hs_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      setup_len  = hs_eff ? '0 : pio_setup;
      raw_strobe = hs_eff ? dma_strobe : pio_strobe;
      hold_len   = hs_eff ? dma_hold : pio_hold;
      strobe_len = (raw_strobe == '0) ? ONE : raw_strobe;
   end

endmodule

// File: rtl/pata_phase_ctr.sv
module pata_phase_ctr #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         last
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= len - W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/pata_word_ctr.sv
module pata_word_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             is_last
);
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= load_val;
      end else if (dec && left_q != '0) begin
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign is_last = (left_q == CNT_W'(1));

endmodule

// File: rtl/pata_host_engine.sv
module pata_host_engine
   import pata_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 16,
   parameter int TIM_W     = 5,
   parameter bit HS_DMA_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [TIM_W-1:0]  cfg_pio_setup,
   input  logic [TIM_W-1:0]  cfg_pio_strobe,
   input  logic [TIM_W-1:0]  cfg_pio_hold,
   input  logic [TIM_W-1:0]  cfg_dma_strobe,
   input  logic [TIM_W-1:0]  cfg_dma_hold,
   input  logic              cnt_we,
   input  logic [CNT_W-1:0]  cnt_words,
   input  logic              ctl_we,
   input  logic [ADDR_W-1:0] ctl_addr,
   input  logic              ctl_rd,
   input  logic              ctl_src_dma,
   input  logic              ctl_hs_dma,
   input  logic              ctl_multi,
   input  logic [DATA_W-1:0] ctl_data,
   output logic              st_busy,
   output logic              st_tr_rdy,
   output logic              st_dav,
   output logic [DATA_W-1:0] st_rdata,
   input  logic [DATA_W-1:0] str_in_data,
   input  logic              str_in_valid,
   output logic              str_in_pop,
   output logic [DATA_W-1:0] str_out_data,
   output logic              str_out_valid,
   output logic [ADDR_W-1:0] ata_addr,
   output logic              ata_dior_n,
   output logic              ata_diow_n,
   output logic [DATA_W-1:0] ata_dout,
   output logic              ata_doe,
   input  logic [DATA_W-1:0] ata_din,
   input  logic              ata_dmarq,
   output logic              ata_dmack_n
);
   localparam int MIN_TIM_W = 5;   // slowest strobe count (19) must fit

   generate
      if (TIM_W < MIN_TIM_W) begin : g_bad_tim
         $error("TIM_W too narrow for the slowest timing mode");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   pata_state_e       state_q, state_d;
   pata_op_t          op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] dout_q, rdata_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q, trdy_q, dav_q, sout_v_q;

   logic              hs_eff;
   logic [TIM_W-1:0]  setup_len, strobe_len, hold_len, ph_len;
   logic              ph_last, ph_load;
   logic              wc_last;
   logic              accept, grant, word_end, stream_wr, in_bus_phase;
   logic [CNT_W-1:0]  wc_init;

   pata_timing_sel #(.TIM_W(TIM_W), .HS_DMA_EN(HS_DMA_EN)) u_tsel (
      .hs_req     (op_q.hs_dma),
      .pio_setup  (cfg_pio_setup),
      .pio_strobe (cfg_pio_strobe),
      .pio_hold   (cfg_pio_hold),
      .dma_strobe (cfg_dma_strobe),
      .dma_hold   (cfg_dma_hold),
      .hs_eff     (hs_eff),
      .setup_len  (setup_len),
      .strobe_len (strobe_len),
      .hold_len   (hold_len)
   );

   pata_phase_ctr #(.W(TIM_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ph_load),
      .len   (ph_len),
      .last  (ph_last)
   );

   pata_word_ctr #(.CNT_W(CNT_W)) u_words (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (wc_init),
      .dec      (word_end),
      .is_last  (wc_last)
   );

   // command acceptance and per-word grant
   always_comb begin
      accept    = cfg_en && ctl_we && (state_q == ST_IDLE);
      stream_wr = op_q.src_dma && !op_q.rd;
      grant     = (state_q == ST_WAIT) && cfg_en
                  && (!hs_eff || ata_dmarq)
                  && (!stream_wr || str_in_valid);
      word_end  = cfg_en && (((state_q == ST_STROBE) && ph_last && (hold_len == '0))
                  || ((state_q == ST_HOLD) && ph_last));
      wc_init   = (ctl_multi && (cnt_q != '0)) ? cnt_q : CNT_W'(1);
      in_bus_phase = (state_q == ST_SETUP) || (state_q == ST_STROBE)
                  || (state_q == ST_HOLD);
   end

   // next state
   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   if (accept) state_d = ST_WAIT;
         ST_WAIT:   if (grant) state_d = (setup_len != '0) ? ST_SETUP : ST_STROBE;
         ST_SETUP:  if (ph_last) state_d = ST_STROBE;
         ST_STROBE: if (ph_last) begin
                       if (hold_len != '0) state_d = ST_HOLD;
                       else                state_d = wc_last ? ST_DONE : ST_WAIT;
                    end
         ST_HOLD:   if (ph_last) state_d = wc_last ? ST_DONE : ST_WAIT;
         ST_DONE:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
      if (!cfg_en) state_d = ST_IDLE;
   end

   // phase counter reload on entry to a bus phase
   always_comb begin
      ph_load = (state_d != state_q)
                && ((state_d == ST_SETUP) || (state_d == ST_STROBE) || (state_d == ST_HOLD));
      case (state_d)
         ST_SETUP:  ph_len = setup_len;
         ST_HOLD:   ph_len = hold_len;
         default:   ph_len = strobe_len;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= '0;
         addr_q   <= '0;
         dout_q   <= '0;
         rdata_q  <= '0;
         cnt_q    <= '0;
         busy_q   <= 1'b0;
         trdy_q   <= 1'b0;
         dav_q    <= 1'b0;
         sout_v_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         sout_v_q <= 1'b0;
         if (cnt_we) cnt_q <= cnt_words;
         if (!cfg_en) begin
            busy_q <= 1'b0;
         end else begin
            if (accept) begin
               op_q.rd      <= ctl_rd;
               op_q.src_dma <= ctl_src_dma;
               op_q.hs_dma  <= ctl_hs_dma;
               addr_q       <= ctl_addr;
               dout_q       <= ctl_data;
               busy_q       <= 1'b1;
               trdy_q       <= 1'b0;
               dav_q        <= 1'b0;
            end
            if (grant) begin
               trdy_q <= 1'b0;
               if (stream_wr) dout_q <= str_in_data;
            end
            if ((state_q == ST_STROBE) && ph_last && op_q.rd) rdata_q <= ata_din;
            if (word_end) begin
               if (op_q.rd) begin
                  dav_q    <= 1'b1;
                  sout_v_q <= op_q.src_dma;
               end else begin
                  trdy_q <= 1'b1;
               end
            end
            if (state_q == ST_DONE) busy_q <= 1'b0;
         end
      end
   end

   assign st_busy       = busy_q;
   assign st_tr_rdy     = trdy_q;
   assign st_dav        = dav_q;
   assign st_rdata      = rdata_q;
   assign str_in_pop    = grant && stream_wr;
   assign str_out_data  = rdata_q;
   assign str_out_valid = sout_v_q;
   assign ata_addr      = addr_q;
   assign ata_dout      = dout_q;
   assign ata_dior_n    = !((state_q == ST_STROBE) && op_q.rd);
   assign ata_diow_n    = !((state_q == ST_STROBE) && !op_q.rd);
   assign ata_doe       = in_bus_phase && !op_q.rd;
   assign ata_dmack_n   = !(in_bus_phase && hs_eff);

endmodule

// File: rtl/pata_host_engine_chk.sv
module pata_host_engine_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic              st_busy,
   input logic              st_tr_rdy,
   input logic              st_dav,
   input logic              str_out_valid,
   input logic [ADDR_W-1:0] ata_addr,
   input logic              ata_dior_n,
   input logic              ata_diow_n,
   input logic              ata_doe,
   input logic              ata_dmack_n
);

   p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_dior_n && !ata_diow_n));

   p_doe_not_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ata_doe |-> ata_dior_n);

   p_strobe_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_dior_n || !ata_diow_n) |-> st_busy);

   p_ready_before_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(st_busy) && $past(cfg_en)) |-> $past(st_tr_rdy || st_dav));

   p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (!st_busy && ata_dior_n && ata_diow_n));

   p_dmack_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ata_dmack_n |-> st_busy);

   p_addr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_busy && $past(st_busy)) |-> $stable(ata_addr));

   p_out_valid_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      str_out_valid |-> st_dav);

endmodule

bind pata_host_engine pata_host_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_en        (cfg_en),
   .st_busy       (st_busy),
   .st_tr_rdy     (st_tr_rdy),
   .st_dav        (st_dav),
   .str_out_valid (str_out_valid),
   .ata_addr      (ata_addr),
   .ata_dior_n    (ata_dior_n),
   .ata_diow_n    (ata_diow_n),
   .ata_doe       (ata_doe),
   .ata_dmack_n   (ata_dmack_n)
);

// File: tb/tb_pata_host_engine.sv
`timescale 1ns/1ps
module tb_pata_host_engine;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 16;
   localparam int CNT_W  = 16;
   localparam int TIM_W  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              cfg_en = 1'b1;
   logic [TIM_W-1:0]  cfg_pio_setup = '0, cfg_pio_strobe = '0, cfg_pio_hold = '0;
   logic [TIM_W-1:0]  cfg_dma_strobe = '0, cfg_dma_hold = '0;
   logic              cnt_we = 1'b0;
   logic [CNT_W-1:0]  cnt_words = '0;
   logic              ctl_we = 1'b0;
   logic [ADDR_W-1:0] ctl_addr = '0;
   logic              ctl_rd = 1'b0, ctl_src_dma = 1'b0, ctl_hs_dma = 1'b0, ctl_multi = 1'b0;
   logic [DATA_W-1:0] ctl_data = '0;
   logic              st_busy, st_tr_rdy, st_dav;
   logic [DATA_W-1:0] st_rdata;
   logic [DATA_W-1:0] str_in_data = '0;
   logic              str_in_valid = 1'b1;
   logic              str_in_pop;
   logic [DATA_W-1:0] str_out_data;
   logic              str_out_valid;
   logic [ADDR_W-1:0] ata_addr;
   logic              ata_dior_n, ata_diow_n, ata_doe, ata_dmack_n;
   logic [DATA_W-1:0] ata_dout;
   logic [DATA_W-1:0] ata_din = '0;
   logic              ata_dmarq = 1'b0;

   pata_host_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TIM_W(TIM_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
      .cfg_pio_setup(cfg_pio_setup), .cfg_pio_strobe(cfg_pio_strobe), .cfg_pio_hold(cfg_pio_hold),
      .cfg_dma_strobe(cfg_dma_strobe), .cfg_dma_hold(cfg_dma_hold),
      .cnt_we(cnt_we), .cnt_words(cnt_words),
      .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_rd(ctl_rd), .ctl_src_dma(ctl_src_dma),
      .ctl_hs_dma(ctl_hs_dma), .ctl_multi(ctl_multi), .ctl_data(ctl_data),
      .st_busy(st_busy), .st_tr_rdy(st_tr_rdy), .st_dav(st_dav), .st_rdata(st_rdata),
      .str_in_data(str_in_data), .str_in_valid(str_in_valid), .str_in_pop(str_in_pop),
      .str_out_data(str_out_data), .str_out_valid(str_out_valid),
      .ata_addr(ata_addr), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
      .ata_dout(ata_dout), .ata_doe(ata_doe), .ata_din(ata_din),
      .ata_dmarq(ata_dmarq), .ata_dmack_n(ata_dmack_n)
   );

   int n_tests = 0;
   int n_fail  = 0;

   function automatic logic [15:0] pat(input int k);
      return 16'(32'h5A3C + k * 32'h1357);
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Issue one command and measure its bus behaviour against the arithmetic model.
   task automatic run_cmd(input string tag, input bit rd, input bit sdma, input bit hdma,
                          input bit multi, input int cnt, input int words,
                          input int S, input int T, input int H, input int dly, input bit poke);
      int tcl, per, i, pulses, first_low, low_cnt, rises, last_rdy, outs, bad, pop_idx, busy0;
      bit prev_stb, prev_rdy, pend_pop, stb, oth, rdy;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data, exp_d;
      tcl = (T == 0) ? 1 : T;
      per = 1 + S + tcl + H;
      addr = ADDR_W'(S + 2 * T + 5 * H + 3 * int'(rd) + 1);
      data = pat(100 + S + T);
      pulses = 0; first_low = -1; low_cnt = 0; rises = 0; last_rdy = -1;
      outs = 0; bad = 0; pop_idx = 0; pend_pop = 1'b0; prev_stb = 1'b0; prev_rdy = 1'b0;
      @(negedge clk);
      cnt_we = 1'b1; cnt_words = CNT_W'(cnt);
      str_in_data = pat(0);
      ata_dmarq = (dly == 0);
      @(negedge clk);
      cnt_we = 1'b0;
      ctl_we = 1'b1; ctl_addr = addr; ctl_rd = rd; ctl_src_dma = sdma;
      ctl_hs_dma = hdma; ctl_multi = multi; ctl_data = data;
      @(negedge clk);
      ctl_we = 1'b0;
      busy0 = int'(st_busy);
      i = 0;
      while (i < 4000) begin
         if (pend_pop) begin pop_idx++; str_in_data = pat(pop_idx); end
         pend_pop = str_in_pop;
         stb = rd ? !ata_dior_n : !ata_diow_n;
         oth = rd ? !ata_diow_n : !ata_dior_n;
         if (oth) bad++;
         if (i < dly && !ata_dmack_n) bad++;
         if (stb) begin
            if (!prev_stb) begin
               pulses++;
               if (pulses == 1) first_low = i;
            end
            low_cnt++;
            if (ata_addr != addr) bad++;
            if (hdma && ata_dmack_n) bad++;
            if (rd) ata_din = pat(pulses - 1);
            else begin
               exp_d = sdma ? pat(pulses - 1) : data;
               if (!ata_doe || ata_dout != exp_d) bad++;
            end
         end
         prev_stb = stb;
         rdy = rd ? st_dav : st_tr_rdy;
         if (rdy && !prev_rdy) begin rises++; last_rdy = i; end
         prev_rdy = rdy;
         if (str_out_valid) begin
            if (str_out_data != pat(outs)) bad++;
            outs++;
         end
         if (poke && i == 2) begin
            ctl_we = 1'b1; ctl_addr = ~addr; ctl_rd = ~rd; ctl_multi = 1'b0;
         end
         if (poke && i == 3) ctl_we = 1'b0;
         if (dly > 0 && i == dly) ata_dmarq = 1'b1;
         if (!st_busy) break;
         @(negedge clk);
         i++;
      end
      check("R2", {tag, " busy after accept"}, busy0, 1);
      check("R6", {tag, " strobe pulses"}, pulses, words);
      check("R3", {tag, " strobe-low cycles"}, low_cnt, words * tcl);
      check("R3", {tag, " first strobe index"}, first_low, dly + 1 + S);
      check("R7", {tag, " busy fall index"}, i, dly + words * per + 1);
      if (!rd) begin
         check("R6", {tag, " tr_rdy rises"}, rises, words);
         check("R7", {tag, " last tr_rdy index"}, last_rdy, dly + words * per);
      end else begin
         check("R5", {tag, " dav index"}, last_rdy, dly + per);
         check("R5", {tag, " read data"}, int'(st_rdata), int'(pat(words - 1)));
      end
      if (rd && sdma) check("R8", {tag, " stream out words"}, outs, words);
      if (!rd && sdma) check("R8", {tag, " stream pops"}, pop_idx, words);
      check(tag, "bus protocol errors", bad, 0);
   endtask

   task automatic set_pio(input int S, input int T, input int H);
      cfg_pio_setup = TIM_W'(S); cfg_pio_strobe = TIM_W'(T); cfg_pio_hold = TIM_W'(H);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "busy", int'(st_busy), 0);
      check("R1", "tr_rdy", int'(st_tr_rdy), 0);
      check("R1", "dav", int'(st_dav), 0);
      check("R1", "strobes/ack/doe", int'({ata_dior_n, ata_diow_n, ata_dmack_n, ata_doe}), 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy after release", int'(st_busy), 0);

      // R3 R4 R5 R6 R7: sweep of timing, direction and burst length
      for (int rd = 0; rd < 2; rd++)
         for (int s = 0; s < 3; s++)
            for (int t = 0; t < 4; t++)
               for (int h = 0; h < 3; h++)
                  for (int m = 0; m < 2; m++) begin
                     set_pio(s, t, h);
                     run_cmd("R4", rd[0], 1'b0, 1'b0, m[0], 3, (m == 1) ? 3 : 1, s, t, h, 0, 1'b0);
                  end

      // R6 count of zero moves one word
      set_pio(1, 2, 1);
      run_cmd("R6", 1'b0, 1'b0, 1'b0, 1'b1, 0, 1, 1, 2, 1, 0, 1'b0);

      // R12 slowest strobe mode
      set_pio(4, 19, 4);
      run_cmd("R12", 1'b1, 1'b0, 1'b0, 1'b0, 0, 1, 4, 19, 4, 0, 1'b0);
      run_cmd("R12", 1'b0, 1'b0, 1'b0, 1'b1, 2, 2, 4, 19, 4, 0, 1'b0);

      // R8 stream source and sink
      set_pio(1, 3, 1);
      run_cmd("R8", 1'b0, 1'b1, 1'b0, 1'b1, 5, 5, 1, 3, 1, 0, 1'b0);
      run_cmd("R8", 1'b1, 1'b1, 1'b0, 1'b1, 4, 4, 1, 3, 1, 0, 1'b0);

      // R9 DMA handshake: setup ignored, DMA counts used, waits for request
      set_pio(3, 7, 3);
      cfg_dma_strobe = TIM_W'(4); cfg_dma_hold = TIM_W'(1);
      run_cmd("R9", 1'b1, 1'b1, 1'b1, 1'b1, 3, 3, 0, 4, 1, 6, 1'b0);
      run_cmd("R9", 1'b0, 1'b1, 1'b1, 1'b1, 2, 2, 0, 4, 1, 0, 1'b0);
      cfg_dma_strobe = TIM_W'(12); cfg_dma_hold = TIM_W'(9);
      run_cmd("R9", 1'b0, 1'b0, 1'b1, 1'b0, 0, 1, 0, 12, 9, 3, 1'b0);

      // R10 command write during busy is ignored
      set_pio(2, 3, 1);
      run_cmd("R10", 1'b0, 1'b0, 1'b0, 1'b1, 2, 2, 2, 3, 1, 0, 1'b1);
      run_cmd("R10", 1'b1, 1'b0, 1'b0, 1'b0, 0, 1, 2, 3, 1, 0, 1'b1);

      // R11 enable low aborts and blocks commands
      set_pio(2, 3, 2);
      @(negedge clk);
      cnt_we = 1'b1; cnt_words = CNT_W'(3);
      @(negedge clk);
      cnt_we = 1'b0; ctl_we = 1'b1; ctl_rd = 1'b0; ctl_multi = 1'b1;
      ctl_src_dma = 1'b0; ctl_hs_dma = 1'b0;
      @(negedge clk);
      ctl_we = 1'b0;
      repeat (3) @(negedge clk);
      check("R11", "busy before disable", int'(st_busy), 1);
      cfg_en = 1'b0;
      @(negedge clk);
      check("R11", "busy after disable", int'(st_busy), 0);
      check("R11", "strobes after disable", int'({ata_dior_n, ata_diow_n}), 3);
      ctl_we = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0;
      @(negedge clk);
      check("R11", "command while disabled", int'(st_busy), 0);
      cfg_en = 1'b1;
      @(negedge clk);
      check("R11", "no late start", int'(st_busy), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule